// File: doc/BRIEF.md
# Carry Lookahead Adder, 16 Bit

This block adds two 16-bit unsigned (or two's-complement, wrapping) operands and a carry-in. It produces a 16-bit sum and a carry-out. Each operand bit pair is classed as one of three kinds. A pair that creates a carry (both bits 1) is a generate. A pair that passes the incoming carry on (exactly one bit 1) is a propagate. A pair that kills the carry (both bits 0) is a stop. The carry into every bit position is then formed directly from those classes, with no serial carry chain.

The carry-in is handled as the generate term of an imaginary position below bit 0, so it goes through the same lookahead equations as any other generate. Every wide AND or OR term in those equations is split into a tree of gates. No gate in the tree has more than `FANIN` inputs (8 by default), so the depth grows with the logarithm of the term width.

A parameter `REG_OUT` picks between two variants. With `REG_OUT` = 1, the default, the sum and carry-out are captured in an output register that resets asynchronously, which gives one cycle of latency. With `REG_OUT` = 0 the outputs are purely combinational.

Top module: `cla_adder16`

## Requirements
- R1: With REG_OUT=1, the value {cout, sum} at the outputs equals a + b + cin (17-bit unsigned result) for the inputs sampled at the previous rising clock edge.
- R2: While rst_n is low, sum and cout are both 0, whatever the operand inputs are.
- R3: When bit 15 of a and bit 15 of b are both 1 (a generate at the top position), cout is 1 whatever the lower bits and cin are.
- R4: When bit 15 of a and bit 15 of b are both 0 (a stop at the top position), cout is 0 whatever the lower bits and cin are.
- R5: When every bit position propagates (a XOR b = 16'hFFFF), cout equals cin, and sum is 16'hFFFF for cin=0 and 16'h0000 for cin=1.
- R6: All-ones plus one (a=16'hFFFF, b=16'h0001, cin=0) gives sum 16'h0000 and cout 1.
- R7: Zero plus zero with cin=0 gives sum 16'h0000 and cout 0.
- R8: The carry-in acts as a generate below bit 0: a=0, b=0, cin=1 gives sum 16'h0001 and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
On every cycle after reset, the assertions compare the registered result with a plain behavioural addition of the previous inputs. They also check the top-position rules: a generate at bit 15 forces a carry-out, and a stop at bit 15 clears it. A third check covers the all-propagate case, where the carry-in runs straight through to the output. Only the bench's directed scenarios can show that the outputs are cleared during reset while the operands are changing. The same is true of the specific corner sums: all-ones plus one, zero plus zero, and a lone carry-in.

// File: rtl/cla_pkg.sv
package cla_pkg;

    typedef enum logic [1:0] {
        CK_STOP = 2'd0,
        CK_PROP = 2'd1,
        CK_GEN  = 2'd2
    } carry_kind_e;

    // Number of tree levels needed to reduce n inputs with a fan-in of f.
    function automatic int tree_levels(input int n, input int f);
        int cnt;
        int lv;
        cnt = n;
        lv  = 0;
        while (cnt > 1) begin
            cnt = (cnt + f - 1) / f;
            lv  = lv + 1;
        end
        if (lv < 1) lv = 1;
        return lv;
    endfunction

endpackage

// File: rtl/cla_bit_class.sv
module cla_bit_class
    import cla_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop
);
    carry_kind_e kind [W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (a[i] && b[i])
                kind[i] = CK_GEN;
            else if (a[i] ^ b[i])
                kind[i] = CK_PROP;
            else
                kind[i] = CK_STOP;
            gen[i]  = (kind[i] == CK_GEN);
            prop[i] = (kind[i] == CK_PROP);
        end
    end

endmodule

// File: rtl/cla_reduce.sv
module cla_reduce
    import cla_pkg::*;
#(
    parameter int N      = 4,
    parameter int FANIN  = 8,
    parameter bit IS_AND = 1'b1
) (
    input  logic [N-1:0] din,
    output logic         y
);
    localparam int LEVELS = tree_levels(N, FANIN);

    logic [N-1:0] stage [LEVELS+1];
    logic         acc;

    // Each node of level l combines up to FANIN nodes of level l-1;
    // nodes past the live count see only identity inputs.
    always_comb begin
        stage[0] = din;
        acc      = IS_AND;
        for (int l = 1; l <= LEVELS; l++) begin
            for (int k = 0; k < N; k++) begin
                acc = IS_AND;
                for (int j = 0; j < FANIN; j++) begin
                    if (k * FANIN + j < N) begin
                        if (IS_AND)
                            acc = acc & stage[l-1][k*FANIN+j];
                        else
                            acc = acc | stage[l-1][k*FANIN+j];
                    end
                end
                stage[l][k] = acc;
            end
        end
    end

    assign y = stage[LEVELS][0];

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
    parameter int W     = 16,
    parameter int FANIN = 8
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         cin,
    output logic [W:0]   carry
);
    // gv[0] is the external carry seen as the generate of a position below bit 0.
    logic [W:0] gv;
    assign gv       = {gen, cin};
    assign carry[0] = cin;

    for (genvar i = 1; i <= W; i++) begin : g_pos
        logic [i:0] term;
        for (genvar t = 0; t <= i; t++) begin : g_term
            if (t == i) begin : g_direct
                assign term[t] = gv[t];
            end else begin : g_prod
                cla_reduce #(.N(i - t + 1), .FANIN(FANIN), .IS_AND(1'b1)) u_and (
                    .din ({prop[i-1:t], gv[t]}),
                    .y   (term[t])
                );
            end
        end
        cla_reduce #(.N(i + 1), .FANIN(FANIN), .IS_AND(1'b0)) u_or (
            .din (term),
            .y   (carry[i])
        );
    end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
    parameter int W       = 16,
    parameter int FANIN   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    typedef struct packed {
        logic [W-1:0] sum;
        logic         cout;
    } result_t;

    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   carry;
    result_t      res_d;
    result_t      res_q;

    cla_bit_class #(.W(W)) u_class (
        .a    (a),
        .b    (b),
        .gen  (gen),
        .prop (prop)
    );

    cla_carry_unit #(.W(W), .FANIN(FANIN)) u_carry (
        .gen   (gen),
        .prop  (prop),
        .cin   (cin),
        .carry (carry)
    );

    always_comb begin
        res_d.sum  = prop ^ carry[W-1:0];
        res_d.cout = carry[W];
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_q <= '0;
            else
                res_q <= res_d;
        end
    end else begin : g_comb
        always_comb res_q = res_d;
    end

    assign sum  = res_q.sum;
    assign cout = res_q.cout;

endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout
);
    if (REG_OUT) begin : g_props
        // R1: registered result matches a behavioural sum of last cycle's inputs
        p_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{W{1'b0}}, $past(cin)})));

        // R3: generate at the top position forces a carry-out
        p_top_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (a[W-1] && b[W-1]) |=> cout);

        // R4: stop at the top position kills the carry-out
        p_top_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!a[W-1] && !b[W-1]) |=> !cout);

        // R5: full propagate chain passes cin straight through
        p_full_prop_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((a ^ b) == {W{1'b1}}) |=> (cout == $past(cin) && sum == {W{!$past(cin)}}));
    end

endmodule

bind cla_adder16 cla_adder16_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout)
);

// File: tb/sim_cla_adder16.sv
module sim_cla_adder16;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NVEC       = 10;
    localparam int NRAND      = 300;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic [W:0]   exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'h1234, 16'h4321, 1'b0, 17'h05555},
        '{16'hFFFF, 16'h0001, 1'b0, 17'h10000},
        '{16'h0000, 16'h0000, 1'b0, 17'h00000},
        '{16'h0000, 16'h0000, 1'b1, 17'h00001},
        '{16'hAAAA, 16'h5555, 1'b1, 17'h10000},
        '{16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
        '{16'h8000, 16'h8000, 1'b0, 17'h10000},
        '{16'h7FFF, 16'h0000, 1'b1, 17'h08000},
        '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
        '{16'h00FF, 16'h0F0F, 1'b0, 17'h0100E}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cla_adder16 u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a),
        .b     (b),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout)
    );

    task automatic check(input string req, input logic [W:0] exp);
        checks++;
        if ({cout, sum} !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, {cout, sum}, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, check at the next falling edge.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc,
                         input string req, input logic [W:0] exp);
        @(negedge clk);
        a   = va;
        b   = vb;
        cin = vc;
        @(negedge clk);
        check(req, exp);
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    initial begin
        // R2: outputs stay cleared in reset while operands move
        @(negedge clk);
        a = 16'hFFFF; b = 16'h0001; cin = 1'b1;
        @(negedge clk);
        check("R2", 17'h00000);
        a = 16'h8000; b = 16'h8000;
        @(negedge clk);
        check("R2", 17'h00000);
        rst_n = 1'b1;

        // R1: table walk
        for (int i = 0; i < NVEC; i++)
            apply(VECS[i].a, VECS[i].b, VECS[i].cin, "R1", VECS[i].exp);

        // R6, R7, R8 corner cases
        apply(16'hFFFF, 16'h0001, 1'b0, "R6", 17'h10000);
        apply(16'h0000, 16'h0000, 1'b0, "R7", 17'h00000);
        apply(16'h0000, 16'h0000, 1'b1, "R8", 17'h00001);

        // R5: every position propagates
        apply(16'hF0F0, 16'h0F0F, 1'b0, "R5", 17'h0FFFF);
        apply(16'hF0F0, 16'h0F0F, 1'b1, "R5", 17'h10000);

        // R3: top generate with assorted low bits
        apply(16'h8000, 16'h8000, 1'b1, "R3", 17'h10001);
        apply(16'hC123, 16'h8001, 1'b0, "R3", 17'h14124);

        // R4: top stop with a full lower propagate run and cin
        apply(16'h7FFF, 16'h0000, 1'b1, "R4", 17'h08000);
        apply(16'h7FFF, 16'h7FFF, 1'b1, "R4", 17'h0FFFF);

        // R1: random vectors against a behavioural sum
        for (int i = 0; i < NRAND; i++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            logic         rc;
            ra = W'($urandom());
            rb = W'($urandom());
            rc = 1'($urandom());
            apply(ra, rb, rc, "R1", model(ra, rb, rc));
        end

        // R2: reset again clears a non-zero result
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R2", 17'h00000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule